// File: doc/BRIEF.md
# Dual-Clock Nine-Bit FIFO with Paired Enables

This block moves 9-bit words from a write clock domain to an independent read clock domain. Each port has two enable inputs, and a transfer on that side takes place only when both are active. The read side can also use an output enable that gates the visible data without disturbing the stored word. The full flag belongs entirely to the write clock and the empty flag belongs entirely to the read clock. Each side learns where the other side's pointer is through a Gray-coded multi-flop synchronizer. Both flags are therefore conservative: a flag may stay asserted for a few cycles after the real condition has ended, but it never releases early.

A producer keeps writing while `full` is low. A consumer reads while `empty` is low. A word that has been read is held in an output register until the next read. The depth is a power-of-two parameter from 64 to 8192 words. The number of synchronizer stages is also a parameter, default 2. All cycle counts below assume that default.

Top module: `dcfifo9_gated`

## Requirements
- R1: While `rst_n` is low, and after it is released, `empty` is 1, `full` is 0 and the output register holds zero. The register reads as 0 on `rd_data` when `out_en` is 1.
- R2: A word is written on a rising `wr_clk` edge only when `wr_en_a` and `wr_en_b` are both 1 and `full` is 0. With either enable at 0, nothing is stored.
- R3: A word is read on a rising `rd_clk` edge only when `rd_en_a` and `rd_en_b` are both 1 and `empty` is 0. At that edge the word is loaded into the output register. Otherwise the register holds its value.
- R4: Words leave in the order they were accepted. From empty, exactly DEPTH words are accepted before `full` blocks further writes.
- R5: `full` rises on the `wr_clk` edge of the write that stores the DEPTH-th word. Write attempts while `full` is 1 store nothing.
- R6: `empty` rises on the `rd_clk` edge of the read that removes the last word. Read attempts while `empty` is 1 leave the pointer and the output register unchanged.
- R7: After a write into an empty FIFO, `empty` falls on the second rising `rd_clk` edge after the write edge. The delay from the write edge is therefore just over one read period when the write edge closely leads a read edge, and approaches two read periods when it closely trails one.
- R8: After a read from a full FIFO, `full` falls on the second rising `wr_clk` edge after the read edge.
- R9: With `out_en` at 1, `rd_data` shows the output register and `rd_drive` is 1. With `out_en` at 0, `rd_data` is 0 and `rd_drive` is 0. The register keeps its content in both cases.
- R10: Each pointer that crosses between domains is Gray coded and changes in at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en_a | input | 1 | First write enable, active high |
| wr_en_b | input | 1 | Second write enable, active high |
| wr_data | input | 9 | Word to store |
| full | output | 1 | No room left, synchronous to `wr_clk` |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| out_en | input | 1 | Output enable for `rd_data` |
| rd_data | output | 9 | Output register when enabled, else zero |
| rd_drive | output | 1 | High when `rd_data` is being driven |
| empty | output | 1 | Nothing to read, synchronous to `rd_clk` |

## Verification
The write and read clocks run at unrelated periods whose edges never coincide. Random patterns on all five enables mix single-enable attempts, which must store or remove nothing, with real transfers, and a reference queue checks the order in which words come out. Directed fill and drain sequences show that exactly DEPTH words are taken and that requests at the flag boundaries are ignored. Repeated single writes into an empty FIFO, each started at a different phase against the read clock, show that the two-edge release rule holds whether the write edge closely leads or closely trails a read edge. A matching read from a full FIFO checks the release of `full`.

// File: rtl/fifo9_pkg.sv
`timescale 1ns/1ps
package fifo9_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fifo9_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, releases on the second local clock edge.
module fifo9_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stg_q <= 2'b00;
    else           stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_out = stg_q[1];
endmodule

// File: rtl/fifo9_ptr_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a Gray-coded pointer.
module fifo9_ptr_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/fifo9_ram.sv
`timescale 1ns/1ps
module fifo9_ram
  import fifo9_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  word_t             wdata,
  input  logic [ADDR_W-1:0] raddr,
  output word_t             rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo9_wr_ctl.sv
`timescale 1ns/1ps
module fifo9_wr_ctl #(
  parameter int ADDR_W = 6,
  localparam int PW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a,
  input  logic              en_b,
  input  logic [PW-1:0]     rgray_sync,
  output logic              full,
  output logic              wr_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PW-1:0]     wgray
);
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Full: Gray pointers differ only in the two top bits.
  assign full = (wgray_q == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});

  always_comb begin
    wr_go   = en_a & en_b & ~full;
    wbin_d  = wbin_q + PW'(wr_go);
    wgray_d = (wbin_d >> 1) ^ wbin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_go) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign wr_addr = wbin_q[ADDR_W-1:0];
  assign wgray   = wgray_q;

  a_r2_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_a && en_b) |=> wbin_q == $past(wbin_q));
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> wbin_q == $past(wbin_q));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wbin_q - g2b(rgray_sync)) <= PW'(DEPTH));
  a_r10_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/fifo9_rd_ctl.sv
`timescale 1ns/1ps
module fifo9_rd_ctl
  import fifo9_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int PW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a,
  input  logic              en_b,
  input  logic [PW-1:0]     wgray_sync,
  input  word_t             mem_word,
  output logic              empty,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PW-1:0]     rgray,
  output word_t             q_word
);
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic          rd_go;
  word_t         q_q, q_d;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign empty = (rgray_q == wgray_sync);

  always_comb begin
    rd_go   = en_a & en_b & ~empty;
    rbin_d  = rbin_q + PW'(rd_go);
    rgray_d = (rbin_d >> 1) ^ rbin_d;
    q_d     = rd_go ? mem_word : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      q_q     <= '0;
    end else begin
      q_q <= q_d;
      if (rd_go) begin
        rbin_q  <= rbin_d;
        rgray_q <= rgray_d;
      end
    end
  end

  assign rd_addr = rbin_q[ADDR_W-1:0];
  assign rgray   = rgray_q;
  assign q_word  = q_q;

  a_r6_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> (rbin_q == $past(rbin_q)) && $stable(q_q));
  a_r3_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_a && en_b) |=> $stable(q_q));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(g2b(wgray_sync) - rbin_q) <= PW'(DEPTH));
  a_r10_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcfifo9_gated.sv
`timescale 1ns/1ps
module dcfifo9_gated
  import fifo9_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       wr_clk,
  input  logic       rd_clk,
  input  logic       rst_n,
  input  logic       wr_en_a,
  input  logic       wr_en_b,
  input  logic [8:0] wr_data,
  output logic       full,
  input  logic       rd_en_a,
  input  logic       rd_en_b,
  input  logic       out_en,
  output logic [8:0] rd_data,
  output logic       rd_drive,
  output logic       empty
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PW     = ADDR_W + 1;

  logic              wrst_n, rrst_n;
  logic              wr_go;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
  word_t             mem_word, q_word;

  fifo9_rst_sync u_wrst (.clk(wr_clk), .rst_n_in(rst_n), .rst_n_out(wrst_n));
  fifo9_rst_sync u_rrst (.clk(rd_clk), .rst_n_in(rst_n), .rst_n_out(rrst_n));

  fifo9_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .en_a(wr_en_a), .en_b(wr_en_b),
    .rgray_sync(rgray_ws), .full(full), .wr_go(wr_go),
    .wr_addr(waddr), .wgray(wgray)
  );

  fifo9_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_rs)
  );

  fifo9_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_ws)
  );

  fifo9_ram #(.ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_word)
  );

  fifo9_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .en_a(rd_en_a), .en_b(rd_en_b),
    .wgray_sync(wgray_rs), .mem_word(mem_word), .empty(empty),
    .rd_addr(raddr), .rgray(rgray), .q_word(q_word)
  );

  assign rd_drive = out_en;
  assign rd_data  = out_en ? q_word : '0;

  a_r1_reset_empty: assert property (@(posedge rd_clk)
    !rrst_n |-> empty);
  a_r1_reset_notfull: assert property (@(posedge wr_clk)
    !wrst_n |-> !full);
endmodule

// File: tb/sim_dcfifo9_gated.sv
`timescale 1ns/1ps
module sim_dcfifo9_gated;
  localparam int  DEPTH      = 64;
  localparam real CLK_PERIOD = 10.0;
  localparam real RCLK_HALF  = 6.35;
  localparam real RPER       = 2.0 * RCLK_HALF;

  logic       wclk, rclk, rst_n;
  logic       wr_en_a, wr_en_b, rd_en_a, rd_en_b, out_en;
  logic [8:0] wr_data, rd_data;
  logic       full, empty, rd_drive;

  int   n_chk, n_err, n_push, n_pop, n_fire;
  bit   wdone, done;
  logic [8:0] model_q [$];
  logic [8:0] last_exp;

  dcfifo9_gated #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data), .full(full),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
    .rd_data(rd_data), .rd_drive(rd_drive), .empty(empty)
  );

  initial begin
    wclk = 1'b0;
    forever #(CLK_PERIOD / 2.0) wclk = ~wclk;
  end

  initial begin
    rclk = 1'b0;
    #1.1;
    forever #(RCLK_HALF) rclk = ~rclk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic wr_cycle(input logic a, input logic b, input logic [8:0] d);
    @(negedge wclk);
    if (n_push - n_pop == DEPTH) chk("R5 full with DEPTH words held", full, 1);
    wr_en_a = a; wr_en_b = b; wr_data = d;
    if (a && b && !full) begin
      model_q.push_back(d);
      n_push++;
    end
  endtask

  task automatic rd_cycle(input logic a, input logic b, input logic oe);
    @(negedge rclk);
    out_en = oe;
    #0.1;
    if (oe) begin
      chk("R3/R4 output word", rd_data, last_exp);
      chk("R9 drive on", rd_drive, 1);
    end else begin
      chk("R9 data gated", rd_data, 0);
      chk("R9 drive off", rd_drive, 0);
    end
    if (n_push == n_pop) chk("R6 empty with nothing stored", empty, 1);
    rd_en_a = a; rd_en_b = b;
    if (a && b && !empty) begin
      last_exp = model_q.pop_front();
      n_pop++;
      n_fire++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int  base, cnt, iter;
    real tw, tf, tl, tr;
    bit  short_seen, long_seen;
    void'($urandom(32'd4242));
    n_chk = 0; n_err = 0; n_push = 0; n_pop = 0; n_fire = 0;
    wdone = 0; done = 0; last_exp = '0;
    rst_n = 0; wr_en_a = 0; wr_en_b = 0; wr_data = '0;
    rd_en_a = 0; rd_en_b = 0; out_en = 1;
    #23;
    chk("R1 empty in reset", empty, 1);
    chk("R1 full in reset", full, 0);
    chk("R1 output in reset", rd_data, 0);
    @(negedge wclk);
    rst_n = 1;
    repeat (6) @(posedge rclk);
    chk("R1 empty after release", empty, 1);
    chk("R1 full after release", full, 0);
    rd_cycle(0, 0, 1);

    // R2: one enable alone stores nothing
    wr_cycle(1, 0, 9'h1AA);
    wr_cycle(0, 1, 9'h155);
    wr_cycle(0, 0, 9'h000);
    repeat (5) rd_cycle(0, 0, 1);
    chk("R2 single enable leaves FIFO empty", empty, 1);

    // R3, R6, R9 directed
    wr_cycle(1, 1, 9'h123);
    wr_cycle(1, 1, 9'h0F0);
    wr_cycle(0, 0, 9'h000);
    repeat (5) rd_cycle(0, 0, 1);
    rd_cycle(1, 0, 1);
    rd_cycle(0, 1, 1);
    rd_cycle(1, 1, 1);
    rd_cycle(0, 0, 0);
    rd_cycle(0, 0, 1);
    rd_cycle(1, 1, 1);
    rd_cycle(0, 0, 1);
    chk("R6 empty after last read", empty, 1);
    rd_cycle(1, 1, 1);
    rd_cycle(0, 0, 1);

    // Random traffic on all enables
    fork
      begin
        for (int i = 0; i < 600; i++)
          wr_cycle(($urandom % 5) != 0, ($urandom % 5) != 0, 9'($urandom));
        wr_cycle(0, 0, 9'h000);
        wdone = 1;
      end
      begin
        iter = 0;
        while ((!wdone || n_push != n_pop) && iter < 8000) begin
          rd_cycle(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0);
          iter++;
        end
        rd_cycle(0, 0, 1);
      end
    join
    chk("R4 random traffic fully drained", n_push - n_pop, 0);

    // R4/R5 fill from empty
    repeat (4) rd_cycle(0, 0, 1);
    base = n_push;
    for (int i = 0; i < DEPTH + 3; i++) wr_cycle(1, 1, 9'($urandom));
    wr_cycle(0, 0, 9'h000);
    chk("R4 words accepted from empty", n_push - base, DEPTH);
    chk("R5 full after DEPTH writes", full, 1);

    // R8 release of full
    rd_cycle(1, 1, 1);
    @(posedge rclk);
    tr = $realtime;
    #0.01;
    rd_en_a = 0; rd_en_b = 0;
    cnt = 0;
    while (full && cnt < 10) begin
      @(posedge wclk);
      cnt++;
      #0.02;
    end
    chk("R8 full release wr_clk edges", cnt, 2);

    base = n_fire;
    iter = 0;
    while (n_push != n_pop && iter < 4 * DEPTH) begin
      rd_cycle(1, 1, 1);
      iter++;
    end
    rd_cycle(0, 0, 1);
    chk("R4 reads to drain after one read", n_fire - base, DEPTH - 1);
    chk("R6 empty after drain", empty, 1);

    // R7 empty release at varied phases
    short_seen = 0; long_seen = 0;
    for (int t = 0; t < 10; t++) begin
      repeat (t + 1) wr_cycle(0, 0, 9'h000);
      wr_cycle(1, 1, 9'($urandom));
      @(posedge wclk);
      tw = $realtime;
      #0.01;
      wr_en_a = 0; wr_en_b = 0;
      cnt = 0; tf = tw; tl = tw;
      while (empty && cnt < 10) begin
        @(posedge rclk);
        cnt++;
        if (cnt == 1) tf = $realtime;
        tl = $realtime;
        #0.02;
      end
      chk("R7 rd_clk edges to empty release", cnt, 2);
      chk("R7 release delay within one to two read periods",
          ((tl - tw) > RPER) && ((tl - tw) < 2.0 * RPER), 1);
      if ((tf - tw) < RPER / 2.0) short_seen = 1;
      else                         long_seen = 1;
      rd_cycle(1, 1, 1);
      rd_cycle(0, 0, 1);
    end
    chk("R7 both leading and trailing phases tried", short_seen && long_seen, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule